// File: doc/BRIEF.md
# Dual-Clock FIFO with In-Band Threshold Loading

This block is a first-in first-out buffer that spans two clock domains. Port A pushes words on its own clock and port B pops them on another, unrelated clock. Each access is qualified by four inputs: an active-low select, a direction bit, a side-channel select that must be low for FIFO traffic, and an enable.

The almost-full and almost-empty thresholds are not set by configuration pins. They travel over the data bus. After every reset, the first four qualified port-A pushes are captured as offsets and are not stored in the buffer. Only then does the input-ready flag rise. The first captured value sets the almost-full margin (Y) and the second sets the almost-empty margin (X). The third and fourth values belong to a reverse-direction buffer that this instance does not contain, so they are consumed and dropped.

Each status flag is computed in the domain that uses it. A flag moves at once when its own side changes the fill level. It follows a change made by the other side only after that side's pointer has passed through a two-stage synchronizer.

Top module: `dcfifo_offs`

## Requirements
- R1: While reset is asserted and right after it is released: `a_ready` is 0, `a_afull` is 0, `b_valid` is 0, `b_aempty` is 1 and `b_dout` is 0.
- R2: After reset, the first four qualified port-A pushes are taken as offsets and do not enter the buffer. The offset is the low log2(DEPTH) bits of `a_din`. The first push sets Y, the second sets X, and the third and fourth are discarded. `a_ready` stays 0 until the fourth of these pushes has completed.
- R3: A port-A push is qualified only on a rising `clk_a` edge with `a_cs_n`=0, `a_wr`=1, `a_mb`=0 and `a_en`=1. Any other combination neither loads an offset nor stores a word.
- R4: A port-B pop is qualified only on a rising `clk_b` edge with `b_cs_n`=0, `b_rd`=1, `b_mb`=0 and `b_en`=1. The popped word appears on `b_dout` at that same edge, and words leave in the order they were stored.
- R5: `a_ready` drops to 0 when DEPTH words are held. A push attempted while it is 0 is ignored.
- R6: `b_valid` is 0 when the buffer is empty. A pop attempted while it is 0 is ignored, and `b_dout` keeps its previous value.
- R7: `a_afull` is 1 exactly when the fill level seen on port A is at least DEPTH−Y. It rises at the push edge that reaches that level. After a pop lowers the level below it, `a_afull` is still 1 after the first following `clk_a` edge and is 0 after the second.
- R8: `b_aempty` is 1 exactly when the fill level seen on port B is at most X. It rises at the pop edge that brings the level down to X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_cs_n | input | 1 | Port A select, active low |
| a_wr | input | 1 | Port A direction, 1 = push |
| a_mb | input | 1 | Port A side-channel select, must be 0 for FIFO access |
| a_en | input | 1 | Port A enable |
| a_din | input | DW | Port A write data; its low bits carry offsets during loading |
| a_ready | output | 1 | Input ready: offsets loaded and buffer not full |
| a_afull | output | 1 | Almost full, in the clk_a domain |
| b_cs_n | input | 1 | Port B select, active low |
| b_rd | input | 1 | Port B direction, 1 = pop |
| b_mb | input | 1 | Port B side-channel select, must be 0 for FIFO access |
| b_en | input | 1 | Port B enable |
| b_dout | output | DW | Port B read data register |
| b_valid | output | 1 | Output ready: buffer not empty, in the clk_b domain |
| b_aempty | output | 1 | Almost empty, in the clk_b domain |

## Verification
The properties assume that every loaded offset lies between 1 and DEPTH−4. They also assume that the X offset stays constant once pushes begin, because the port-B flag logic reads it without a synchronizer. The stimulus loads Y=3 and X=2 only once, straight after reset. It sends no data until the fourth offset push has completed. It drives each port's inputs on the falling edge of that port's own clock, so the inputs are steady at every sampling edge.

// File: rtl/dcfifo_offs.sv
module dcfifo_offs #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic          a_cs_n,
  input  logic          a_wr,
  input  logic          a_mb,
  input  logic          a_en,
  input  logic [DW-1:0] a_din,
  output logic          a_ready,
  output logic          a_afull,
  input  logic          b_cs_n,
  input  logic          b_rd,
  input  logic          b_mb,
  input  logic          b_en,
  output logic [DW-1:0] b_dout,
  output logic          b_valid,
  output logic          b_aempty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
  logic [2:0]    ld_cnt;
  logic [AW-1:0] yoff, xoff;

  wire a_q    = !a_cs_n && a_wr && !a_mb && a_en;
  wire b_q    = !b_cs_n && b_rd && !b_mb && b_en;
  wire loaded = ld_cnt[2];

  wire [PW-1:0] wcnt   = wbin - g2b(rg_s2);
  wire          full   = (wcnt == FULL_LVL);
  wire          do_wr  = a_q && loaded && !full;
  wire [PW-1:0] wbin_n = wbin + 1'b1;

  assign a_ready = loaded && !full;
  assign a_afull = loaded && (wcnt >= FULL_LVL - {1'b0, yoff});

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      ld_cnt <= '0;
      yoff   <= '0;
      xoff   <= '0;
      wbin   <= '0;
      wgray  <= '0;
      rg_s1  <= '0;
      rg_s2  <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (a_q && !loaded) begin
        ld_cnt <= ld_cnt + 3'd1;
        if (ld_cnt == 3'd0) yoff <= a_din[AW-1:0];
        if (ld_cnt == 3'd1) xoff <= a_din[AW-1:0];
      end
      if (do_wr) begin
        wbin  <= wbin_n;
        wgray <= wbin_n ^ (wbin_n >> 1);
      end
    end
  end

  always_ff @(posedge clk_a) begin
    if (do_wr) mem[wbin[AW-1:0]] <= a_din;
  end

  wire [PW-1:0] rcnt   = g2b(wg_s2) - rbin;
  wire          empty  = (rcnt == '0);
  wire          do_rd  = b_q && !empty;
  wire [PW-1:0] rbin_n = rbin + 1'b1;

  assign b_valid  = !empty;
  assign b_aempty = (rcnt <= {1'b0, xoff});

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      wg_s1  <= '0;
      wg_s2  <= '0;
      b_dout <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (do_rd) begin
        rbin   <= rbin_n;
        rgray  <= rbin_n ^ (rbin_n >> 1);
        b_dout <= mem[rbin[AW-1:0]];
      end
    end
  end
endmodule

// File: rtl/dcfifo_offs_chk.sv
module dcfifo_offs_chk #(
  parameter int PW = 5
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          rst_n,
  input logic          a_cs_n,
  input logic          a_wr,
  input logic          a_mb,
  input logic          a_en,
  input logic          a_ready,
  input logic          a_afull,
  input logic          b_cs_n,
  input logic          b_rd,
  input logic          b_mb,
  input logic          b_en,
  input logic          b_valid,
  input logic          b_aempty,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin
);
  wire aq = !a_cs_n && a_wr && !a_mb && a_en;
  wire bq = !b_cs_n && b_rd && !b_mb && b_en;

  logic [2:0] seen;
  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (aq && seen != 3'd4) seen <= seen + 3'd1;
  end

  assert_ready_held_R2: assert property (@(posedge clk_a) disable iff (!rst_n)
    (seen != 3'd4) |-> !a_ready);

  assert_no_overflow_R5: assert property (@(posedge clk_a) disable iff (!rst_n)
    (aq && !a_ready) |=> $stable(wbin));

  assert_no_underflow_R6: assert property (@(posedge clk_b) disable iff (!rst_n)
    (bq && !b_valid) |=> $stable(rbin));

  assert_full_implies_afull_R7: assert property (@(posedge clk_a) disable iff (!rst_n)
    (seen == 3'd4 && !a_ready) |-> a_afull);

  assert_empty_implies_aempty_R8: assert property (@(posedge clk_b) disable iff (!rst_n)
    !b_valid |-> b_aempty);
endmodule

bind dcfifo_offs dcfifo_offs_chk #(.PW(PW)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
  .a_cs_n(a_cs_n), .a_wr(a_wr), .a_mb(a_mb), .a_en(a_en),
  .a_ready(a_ready), .a_afull(a_afull),
  .b_cs_n(b_cs_n), .b_rd(b_rd), .b_mb(b_mb), .b_en(b_en),
  .b_valid(b_valid), .b_aempty(b_aempty),
  .wbin(wbin), .rbin(rbin)
);

// File: tb/sim_dcfifo_offs.sv
`timescale 1ns/1ps
module sim_dcfifo_offs;
  logic clk_a = 0, clk_b = 0, rst_n = 0;
  logic a_cs_n = 1, a_wr = 0, a_mb = 0, a_en = 0;
  logic [7:0] a_din = 0;
  logic b_cs_n = 1, b_rd = 0, b_mb = 0, b_en = 0;
  logic a_ready, a_afull, b_valid, b_aempty;
  logic [7:0] b_dout;
  int n_run = 0, n_fail = 0;

  always #5 clk_a = ~clk_a;
  always #7 clk_b = ~clk_b;

  dcfifo_offs #(.DW(8), .DEPTH(16)) u0 (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_wr(a_wr), .a_mb(a_mb), .a_en(a_en), .a_din(a_din),
    .a_ready(a_ready), .a_afull(a_afull),
    .b_cs_n(b_cs_n), .b_rd(b_rd), .b_mb(b_mb), .b_en(b_en),
    .b_dout(b_dout), .b_valid(b_valid), .b_aempty(b_aempty)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic a_put(input logic [7:0] d, input logic cs_n = 0, input logic wr = 1,
                       input logic mb = 0, input logic en = 1);
    @(negedge clk_a);
    a_cs_n = cs_n; a_wr = wr; a_mb = mb; a_en = en; a_din = d;
    @(posedge clk_a); #1;
    a_cs_n = 1; a_en = 0; a_wr = 0; a_mb = 0;
  endtask

  task automatic b_get(output logic [7:0] d, input logic cs_n = 0, input logic rd = 1,
                       input logic mb = 0, input logic en = 1);
    @(negedge clk_b);
    b_cs_n = cs_n; b_rd = rd; b_mb = mb; b_en = en;
    @(posedge clk_b); #1;
    d = b_dout;
    b_cs_n = 1; b_en = 0; b_rd = 0; b_mb = 0;
  endtask

  task automatic wait_b(input int n);
    repeat (n) @(posedge clk_b);
    #1;
  endtask

  task automatic t_reset;
    chk("R1", "a_ready", a_ready, 0);
    chk("R1", "a_afull", a_afull, 0);
    chk("R1", "b_valid", b_valid, 0);
    chk("R1", "b_aempty", b_aempty, 1);
    chk("R1", "b_dout", b_dout, 0);
  endtask

  task automatic t_load;
    a_put(8'h05, 0, 1, 1, 1);           // R3: side-channel push is not a load
    a_put(8'h03);                       // Y = 3
    a_put(8'h02);                       // X = 2
    chk("R2", "a_ready after two loads", a_ready, 0);
    a_put(8'h09);
    chk("R3", "a_ready after three loads plus one unqualified", a_ready, 0);
    a_put(8'h09);
    chk("R2", "a_ready after four loads", a_ready, 1);
    wait_b(6);
    chk("R2", "b_valid after loads", b_valid, 0);
  endtask

  task automatic t_qual;
    a_put(8'hAA, 1, 1, 0, 1);
    a_put(8'hAB, 0, 0, 0, 1);
    a_put(8'hAC, 0, 1, 1, 1);
    a_put(8'hAD, 0, 1, 0, 0);
    wait_b(6);
    chk("R3", "b_valid after unqualified pushes", b_valid, 0);
  endtask

  task automatic t_order;
    logic [7:0] d;
    a_put(8'h11); a_put(8'h22); a_put(8'h33); a_put(8'h44);
    wait_b(4);
    chk("R4", "b_valid with 4 words", b_valid, 1);
    chk("R8", "b_aempty at level 4", b_aempty, 0);
    b_get(d, 0, 1, 1, 1);
    b_get(d, 1, 1, 0, 1);
    b_get(d, 0, 0, 0, 1);
    b_get(d, 0, 1, 0, 0);
    chk("R4", "b_dout after unqualified pops", b_dout, 0);
    b_get(d); chk("R4", "pop 1", d, 8'h11);
    chk("R8", "b_aempty at level 3", b_aempty, 0);
    b_get(d); chk("R4", "pop 2", d, 8'h22);
    chk("R8", "b_aempty at level 2", b_aempty, 1);
    b_get(d); chk("R4", "pop 3", d, 8'h33);
    b_get(d); chk("R4", "pop 4", d, 8'h44);
    chk("R6", "b_valid when drained", b_valid, 0);
    b_get(d);
    chk("R6", "b_dout held on empty pop", d, 8'h44);
    chk("R6", "b_valid after empty pop", b_valid, 0);
  endtask

  task automatic t_full;
    logic [7:0] d;
    for (int i = 0; i < 12; i++) a_put(8'h40 + 8'(i));
    chk("R7", "a_afull at level 12", a_afull, 0);
    a_put(8'h4C);
    chk("R7", "a_afull at level 13", a_afull, 1);
    chk("R5", "a_ready at level 13", a_ready, 1);
    a_put(8'h4D); a_put(8'h4E); a_put(8'h4F);
    chk("R5", "a_ready at level 16", a_ready, 0);
    a_put(8'hEE);
    wait_b(4);
    for (int i = 0; i < 4; i++) begin
      b_get(d); chk("R5", "pop head", d, 8'h40 + i);
    end
    @(posedge clk_a); #1;
    chk("R7", "a_afull one clk_a edge after pop", a_afull, 1);
    @(posedge clk_a); #1;
    chk("R7", "a_afull two clk_a edges after pop", a_afull, 0);
    chk("R5", "a_ready at level 12", a_ready, 1);
    for (int i = 4; i < 16; i++) begin
      b_get(d); chk("R5", "pop tail", d, 8'h40 + i);
    end
    chk("R5", "b_valid after 16 pops, rejected push absent", b_valid, 0);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2;
    t_reset;
    #31 rst_n = 1;
    #1;
    t_reset;
    t_load;
    t_qual;
    t_order;
    t_full;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule